// File: doc/BRIEF.md
# Timer Channel with Edge-Triggered Time-Base Capture

This block is one channel of a timer subsystem. A seven-bit mode field in its control register selects one of three behaviours. In the first, the pin is a plain input: the channel watches it for a chosen transition and raises a flag. In the second, the pin is a plain output: the channel drives it from a control bit. In the third, the same transition copies the value on an external 24-bit time-base bus into a capture register and raises the flag.

The input pin is first passed through a two-stage synchronizer. A single edge detector then serves both the input-flagging mode and the capture mode. The trigger can be the rising edge, the falling edge, or either edge. Each new capture overwrites the previous one without waiting for software to read it. The edge-history register keeps running in every mode, so the channel can capture from the first cycle after it leaves a plain I/O mode.

Software reaches the channel through a simple synchronous write port and a combinational read port. There are three addresses: control, status, and capture data. The time-base counter, any noise filter on the pin and interrupt or DMA routing belong to the surrounding subsystem.

Top module: `tmr_capt_channel`

## Requirements
- R1: After reset the control register reads 0 (plain input, falling edge, single edge), the flag is 0, the capture register is 0 and the output pin is 0.
- R2: Address 0 is the control register: mode in bits 6:0, edge-polarity in bit 7, either-edge in bit 8. It reads back what was written and changes only on a write to address 0. Address 1 is status: flag in bit 0, synchronized pin level in bit 1. Address 2 returns the capture register in bits 23:0. Address 3 reads 0.
- R3: The trigger is chosen as follows. When either-edge is 1, both transitions qualify. When it is 0, polarity 1 selects rising and polarity 0 selects falling. A pin change made before clock edge k is flagged at edge k+2, after two synchronizer stages and the edge register.
- R4: In capture mode (7'h02), a qualifying edge loads the time-base value present at the flag-setting clock edge into the capture register, and sets the flag on that same edge.
- R5: Every later qualifying edge in capture mode overwrites the capture register and sets the flag again. No read is needed between captures.
- R6: In plain input mode (7'h00), a qualifying edge sets the flag and leaves the capture register unchanged. Status bit 1 always reports the synchronized pin level.
- R7: In plain output mode (7'h01), the output pin takes the polarity bit one clock after the control register holds it. Edges on the input pin set no flag in this mode, and the output pin holds its value in other modes.
- R8: Writing status with bit 0 set clears the flag. Writing it with bit 0 clear has no effect. If a clear and a new event land on the same clock edge, the flag stays set.
- R9: An edge that arrives right after the mode is switched from plain I/O into capture mode is captured, with no arming step.
- R10: Mode values other than 7'h00, 7'h01 and 7'h02 neither set the flag nor change the capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous channel input pin |
| tbase_i | input | 24 | Selected time-base bus value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 9 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 24 | Register read data (combinational) |
| pin_o | output | 1 | Channel output pin (registered) |
| flag_o | output | 1 | Event flag |

## Verification
The flag has two writers that can act on the same clock edge: a qualifying pin edge that sets it, and a software write-one that clears it. The bench provokes the collision by timing the status write so that its strobe covers the exact edge on which a capture lands, two clocks after the pin change. It then expects the flag to stay set and the capture register to hold the new time-base value. A clear issued alone afterwards must drop the flag, which shows that the write path itself works.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  localparam int MODE_W = 7;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = MODE_W + 2;

  localparam logic [MODE_W-1:0] MODE_PIN_IN  = 7'h00;
  localparam logic [MODE_W-1:0] MODE_PIN_OUT = 7'h01;
  localparam logic [MODE_W-1:0] MODE_CAPTURE = 7'h02;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CAPT = 2'd2;

  localparam int POL_BIT  = MODE_W;
  localparam int BOTH_BIT = MODE_W + 1;

  typedef struct packed {
    logic              both;
    logic              pol;
    logic [MODE_W-1:0] mode;
  } ctrl_t;

  // Trigger selection: both edges, or one edge picked by polarity.
  function automatic logic edge_qualifies(input logic rise, input logic fall,
                                          input logic pol, input logic both);
    if (both) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // Modes in which the edge detector feeds the flag.
  function automatic logic mode_flags(input logic [MODE_W-1:0] mode);
    return (mode == MODE_PIN_IN) || (mode == MODE_CAPTURE);
  endfunction

endpackage

// File: rtl/tcc_pin_sync.sv
module tcc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  // Edge history runs in every mode so capture is ready at once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o})); // R3
  AST_RISE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> prev_q); // R3

endmodule

// File: rtl/tcc_ctrl_reg.sv
module tcc_ctrl_reg
  import tcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  output ctrl_t             ctrl_o,
  output logic              clr_req_o
);
  ctrl_t ctrl_q;
  logic  ctrl_wr;

  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign clr_req_o = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data);
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q)); // R2

endmodule

// File: rtl/tcc_event_unit.sv
module tcc_event_unit
  import tcc_pkg::*;
#(
  parameter int TB_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctrl_t           ctrl_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            clr_req_i,
  input  logic [TB_W-1:0] tbase_i,
  output logic [TB_W-1:0] capt_o,
  output logic            flag_o,
  output logic            pin_o
);
  logic            trig;
  logic            cap_hit;
  logic            flag_hit;
  logic [TB_W-1:0] capt_q;
  logic            flag_q;
  logic            pin_q;
  logic            quiet_mode;

  assign trig       = edge_qualifies(rise_i, fall_i, ctrl_i.pol, ctrl_i.both);
  assign flag_hit   = trig && mode_flags(ctrl_i.mode);
  assign cap_hit    = trig && (ctrl_i.mode == MODE_CAPTURE);
  assign quiet_mode = !mode_flags(ctrl_i.mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       capt_q <= '0;
    else if (cap_hit) capt_q <= tbase_i;
  end

  // Set has priority over a simultaneous software clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (flag_hit)  flag_q <= 1'b1;
    else if (clr_req_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           pin_q <= 1'b0;
    else if (ctrl_i.mode == MODE_PIN_OUT) pin_q <= ctrl_i.pol;
  end

  assign capt_o = capt_q;
  assign flag_o = flag_q;
  assign pin_o  = pin_q;

  AST_CAPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (capt_q == $past(tbase_i))); // R4
  AST_CAPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_hit |=> $stable(capt_q)); // R6
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_hit |=> flag_q); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req_i && !flag_hit) |=> !flag_q); // R8
  AST_QUIET_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_mode && !clr_req_i) |=> $stable(flag_q)); // R10
  AST_PIN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.mode == MODE_PIN_OUT) |=> (pin_q == $past(ctrl_i.pol))); // R7
  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.mode != MODE_PIN_OUT) |=> $stable(pin_q)); // R7

endmodule

// File: rtl/tmr_capt_channel.sv
module tmr_capt_channel
  import tcc_pkg::*;
#(
  parameter int TB_W     = 24,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic [TB_W-1:0]   tbase_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TB_W-1:0]   rd_data,
  output logic              pin_o,
  output logic              flag_o
);
  localparam int RD_W = (TB_W > CTRL_W) ? TB_W : CTRL_W;

  ctrl_t           ctrl;
  logic            clr_req;
  logic            level;
  logic            rise;
  logic            fall;
  logic [TB_W-1:0] capt;
  logic [RD_W-1:0] rd_mux;

  tcc_pin_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  tcc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_o(ctrl), .clr_req_o(clr_req)
  );

  tcc_event_unit #(.TB_W(TB_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .rise_i(rise), .fall_i(fall),
    .clr_req_i(clr_req), .tbase_i(tbase_i), .capt_o(capt),
    .flag_o(flag_o), .pin_o(pin_o)
  );

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      ADDR_CTRL: rd_mux[CTRL_W-1:0] = ctrl;
      ADDR_STAT: rd_mux[1:0]        = {level, flag_o};
      ADDR_CAPT: rd_mux[TB_W-1:0]   = capt;
      default:   rd_mux             = '0;
    endcase
  end

  assign rd_data = rd_mux[TB_W-1:0];

endmodule

// File: tb/tmr_capt_channel_tb.sv
module tmr_capt_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_i = 1'b0;
  logic [23:0] tbase_i = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [8:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [23:0] rd_data;
  logic        pin_o;
  logic        flag_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model state
  logic [6:0]  m_mode = 7'h00;
  logic        m_pol = 1'b0, m_both = 1'b0;
  logic        m_lvl = 1'b0, m_flag = 1'b0, m_pout = 1'b0;
  logic [23:0] m_capt = '0;

  tmr_capt_channel u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .tbase_i(tbase_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_o(pin_o), .flag_o(flag_o)
  );

  always #4 clk = ~clk;

  function automatic bit fires(input logic o, input logic n,
                               input logic pol, input logic both);
    bit up, dn;
    up = (!o && n);
    dn = (o && !n);
    if (both) return up || dn;
    if (pol)  return up;
    return dn;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [23:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input logic [6:0] mode, input logic pol, input logic both);
    wr(2'd0, {both, pol, mode});
    m_mode = mode; m_pol = pol; m_both = both;
    if (mode == 7'h01) m_pout = pol;
    @(negedge clk);
  endtask

  task automatic model_edge(input logic v, input logic [23:0] tb);
    if ((v != m_lvl) && fires(m_lvl, v, m_pol, m_both)) begin
      if (m_mode == 7'h00 || m_mode == 7'h02) m_flag = 1'b1;
      if (m_mode == 7'h02) m_capt = tb;
    end
    m_lvl = v;
  endtask

  task automatic pin_event(input logic v, input logic [23:0] tb);
    @(negedge clk);
    pin_i = v; tbase_i = tb;
    repeat (3) @(negedge clk);
    model_edge(v, tb);
  endtask

  task automatic check_all(input string tag);
    logic [23:0] d;
    chk({tag, " R6 flag"}, flag_o, m_flag);
    rd(2'd1, d);
    chk({tag, " R6 status"}, d, {22'd0, m_lvl, m_flag});
    rd(2'd2, d);
    chk({tag, " R4 capture"}, d, m_capt);
    chk({tag, " R7 pin_o"}, pin_o, m_pout);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [23:0] d;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    rd(2'd1, d); chk("R1 status", d, 0);
    rd(2'd2, d); chk("R1 capture", d, 0);
    chk("R1 pin_o", pin_o, 0);
    chk("R1 flag", flag_o, 0);

    // R2 register readback and unused address
    set_ctrl(7'h02, 1'b1, 1'b1);
    rd(2'd0, d); chk("R2 ctrl readback", d, 24'h182);
    rd(2'd3, d); chk("R2 addr3 zero", d, 0);
    wr(2'd2, 9'h0ff);
    rd(2'd0, d); chk("R2 ctrl unchanged", d, 24'h182);

    // R4 single capture, R3 latency: flag not yet up two edges after change
    set_ctrl(7'h02, 1'b1, 1'b0);
    @(negedge clk); pin_i = 1'b1; tbase_i = 24'h001000;
    repeat (2) @(negedge clk);
    chk("R3 latency not early", flag_o, 0);
    @(negedge clk);
    model_edge(1'b1, 24'h001000);
    check_all("R4 first");

    // R5 overwrite without read, flag already set
    pin_event(1'b0, 24'h001100);  // falling not selected
    pin_event(1'b1, 24'h001250);
    check_all("R5 overwrite");

    // R8 clear, write of zero has no effect
    wr(2'd1, 9'h000);
    chk("R8 zero write", flag_o, 1);
    wr(2'd1, 9'h001); m_flag = 1'b0;
    chk("R8 clear", flag_o, 0);

    // R8 collision: clear strobe on the capturing edge
    @(negedge clk); pin_i = 1'b0; tbase_i = 24'h0016a0;
    set_ctrl(7'h02, 1'b0, 1'b0);  // not used for timing; re-align below
    pin_i = 1'b1; m_lvl = 1'b0;   // return quietly to start level 1 after settle
    repeat (3) @(negedge clk);
    m_lvl = 1'b1; m_flag = flag_o; m_capt = m_capt;
    wr(2'd1, 9'h001); m_flag = 1'b0;
    pin_i = 1'b0; tbase_i = 24'h0016a0;        // change before posedge P1
    @(negedge clk);                           // after P1
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 9'h001;  // covers P2
    @(negedge clk);
    wr_addr = 2'd1;                           // keep strobe for P3
    @(negedge clk);
    wr_en = 1'b0;
    model_edge(1'b0, 24'h0016a0);
    chk("R8 set wins flag", flag_o, 1);
    rd(2'd2, d); chk("R8 set wins capture", d, 24'h0016a0);
    wr(2'd1, 9'h001); m_flag = 1'b0;
    chk("R8 clear after", flag_o, 0);

    // R9 edge right after leaving plain input mode
    set_ctrl(7'h00, 1'b1, 1'b1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = {1'b1, 1'b1, 7'h02};
    pin_i = 1'b1; tbase_i = 24'h00abcd;
    @(negedge clk);
    wr_en = 1'b0;
    m_mode = 7'h02;
    repeat (2) @(negedge clk);
    model_edge(1'b1, 24'h00abcd);
    check_all("R9 immediate");
    wr(2'd1, 9'h001); m_flag = 1'b0;

    // R10 reserved mode quiet
    set_ctrl(7'h45, 1'b0, 1'b1);
    pin_event(1'b0, 24'h123456);
    check_all("R10 reserved");

    // R7 output mode drives polarity
    set_ctrl(7'h01, 1'b1, 1'b1);
    chk("R7 drive high", pin_o, 1);
    pin_event(1'b1, 24'h000777);
    check_all("R7 no flag");
    set_ctrl(7'h01, 1'b0, 1'b0);
    chk("R7 drive low", pin_o, 0);
    set_ctrl(7'h00, 1'b1, 1'b0);
    chk("R7 hold", pin_o, 0);

    // Random phase across modes and edge selections (R3, R4, R5, R6)
    for (int i = 0; i < 160; i++) begin
      logic [6:0] md;
      case ($urandom % 6)
        0, 1: md = 7'h02;
        2, 3: md = 7'h00;
        4:    md = 7'h01;
        default: md = 7'h07;
      endcase
      if (($urandom % 3) == 0)
        set_ctrl(md, 1'($urandom), 1'($urandom));
      pin_event(1'($urandom), 24'($urandom));
      check_all("R3 random");
      if (($urandom % 4) == 0) begin
        wr(2'd1, 9'h001); m_flag = 1'b0;
        chk("R8 random clear", flag_o, 0);
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule